// File: doc/BRIEF.md
# Delay-Line DLL Programming Sequencer

This block is a small register-bus master that reprograms the delay line of a delay-locked loop used by a storage card interface. A client hands it one request that carries a 7-bit delay code and a kind select. The kind select chooses the clock-sample delay or the read-strobe delay. The sequencer then runs a fixed chain of reads and writes on three configuration registers and waits for the loop to report lock. It ends with a one-cycle completion pulse and a cause code.

The chain has two phases. In the first phase the sequencer reads the main control word and writes it back with its mode fields cleared and the start and lock-count values loaded. It then reads the delay word, replaces only the selected delay field and writes it back. In the second phase it reads the control word again and writes it back with the set strobe raised. It then polls the status word for the lock flag, with a bounded number of reads. Any bus error response ends the chain at once.

A typical use is the tuning loop of the card host. It sweeps the clock-sample code one value at a time. Before double-data-rate tuning it presets the read-strobe code to 32, which gives a quarter-period (90 degree) shift.

Top module: `dll_delay_programmer`

## Requirements
- R1: After reset, busy, done and bus_req are low and req_ready is high.
- R2: A request is taken in a cycle where req_valid and req_ready are both high. busy is high from the next cycle up to and including the single cycle in which done is high, and it is low in the cycle after done.
- R3: The transactions come in this fixed order: read 0x1B0, write 0x1B0, read 0x1B4, write 0x1B4, read 0x1B0, write 0x1B0, then reads of 0x1B8. bus_req and the transaction fields hold until bus_ack is seen.
- R4: The first write to 0x1B0 takes the value just read and forces these fields to zero: bits 7:0, bit 8, bits 18:16, bits 22:20, bit 23 and bit 24. It then sets bits 7:0 to 4 and bits 18:16 to 4, and keeps all other bits.
- R5: The write to 0x1B4 takes the value just read and replaces one field with the request code. That field is bits 14:8 when req_kind is 0 (clock-sample) and bits 6:0 when req_kind is 1 (read-strobe). All other bits are kept.
- R6: The second write to 0x1B0 takes the value just read and sets bits 7:0 to 4, bits 18:16 to 4 and bit 8 to 1. All other bits are kept.
- R7: Reads of 0x1B8 repeat until bit 2 reads as 1. Lock seen on any of the first MAX_POLLS reads, including the last one, ends the run with done_err low and done_cause 0. The other bits of the status word are ignored.
- R8: If MAX_POLLS reads (default 1000) all show bit 2 low, the run ends with done_err high and done_cause 2, and no further read is made.
- R9: A bus_err together with bus_ack ends the run at once, with done_err high and done_cause 1. The failed transaction has no effect and no further transaction is issued.
- R10: While busy, req_ready is low and req_valid is ignored. req_code and req_kind are sampled only at acceptance, so changing them later does not change what is written.
- R11: A read-strobe request with code 32, the 90-degree preset, writes 0x20 into bits 6:0 of 0x1B4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 1 | 0 clock-sample delay, 1 read-strobe delay |
| req_code | input | 7 | Delay code to program |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Run failed; valid with done |
| done_cause | output | 2 | 0 ok, 1 bus fault, 2 lock timeout; valid with done |
| bus_req | output | 1 | Transaction request, held until bus_ack |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transaction complete |
| bus_err | input | 1 | Error response, valid with bus_ack |

## Verification
A wrong step in the chain shows up on the bus within one transaction: a wrong address or direction appears in the cycle the request is raised. A wrong merged word is visible in the register model once the sequence completes. A stuck or early poll exit shows up at done as a wrong poll count or cause. A lock on the final permitted read separates an off-by-one bound from a correct one. A leaked abort shows up as an extra write counted after the faulted transaction. A sampling fault shows up as the delay field taking a value that was driven only while the block was busy.

// File: rtl/dlyseq_pkg.sv
// Shared types, field positions and merge functions for the DLL
// programming sequencer. Assumes 32-bit configuration words.
package dlyseq_pkg;

    localparam int DLY_W       = 7;
    localparam int WORD_W      = 32;
    localparam int START_LSB   = 0;
    localparam int START_W     = 8;
    localparam int SET_BIT     = 8;
    localparam int LOCKN_LSB   = 16;
    localparam int LOCKN_W     = 3;
    localparam int PHDET_LSB   = 20;
    localparam int PHDET_W     = 3;
    localparam int BYPASS_BIT  = 23;
    localparam int HALF_BIT    = 24;
    localparam int STRB_LSB    = 0;
    localparam int SAMP_LSB    = 8;
    localparam int LOCKED_BIT  = 2;
    localparam int START_CODE  = 4;
    localparam int LOCKN_CODE  = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CTL_A, S_WR_CTL_A, S_RD_DLY, S_WR_DLY,
        S_RD_CTL_B, S_WR_CTL_B, S_POLL, S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_BUS    = 2'd1,
        RES_NOLOCK = 2'd2
    } seq_result_e;

    typedef enum logic {
        KIND_SAMPLE = 1'b0,
        KIND_STROBE = 1'b1
    } dly_kind_e;

    // Mask covering start, strobe and lock count fields.
    function automatic word_t core_mask();
        word_t m;
        m = '0;
        m[START_LSB +: START_W] = '1;
        m[SET_BIT]              = 1'b1;
        m[LOCKN_LSB +: LOCKN_W] = '1;
        return m;
    endfunction

    // Start value and lock count loaded together.
    function automatic word_t core_load();
        word_t v;
        v = '0;
        v[START_LSB +: START_W] = START_W'(START_CODE);
        v[LOCKN_LSB +: LOCKN_W] = LOCKN_W'(LOCKN_CODE);
        return v;
    endfunction

    // First control write: clear every mode field, load start/lock count.
    function automatic word_t ctl_prepare(word_t old);
        word_t m;
        m = core_mask();
        m[PHDET_LSB +: PHDET_W] = '1;
        m[BYPASS_BIT]           = 1'b1;
        m[HALF_BIT]             = 1'b1;
        return (old & ~m) | core_load();
    endfunction

    // Second control write: reload start/lock count with strobe high.
    function automatic word_t ctl_commit(word_t old);
        word_t v;
        v = core_load();
        v[SET_BIT] = 1'b1;
        return (old & ~core_mask()) | v;
    endfunction

    // Delay word merge: replace only the field picked by kind.
    function automatic word_t dly_merge(word_t old, dly_kind_e kind,
                                        logic [DLY_W-1:0] code);
        word_t v;
        v = old;
        if (kind == KIND_STROBE) v[STRB_LSB +: DLY_W] = code;
        else                     v[SAMP_LSB +: DLY_W] = code;
        return v;
    endfunction

endpackage

// File: rtl/dlyseq_req_capture.sv
// Request capture: latches the delay code and kind on acceptance only.
// Assumes accept is a single-cycle qualifier from the sequencer.
module dlyseq_req_capture
    import dlyseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             busy,
    input  logic             kind_in,
    input  logic [DLY_W-1:0] code_in,
    output dly_kind_e        kind_q,
    output logic [DLY_W-1:0] code_q
);

    // Hold the request fields from acceptance to the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_SAMPLE;
            code_q <= '0;
        end else if (accept) begin
            kind_q <= dly_kind_e'(kind_in);
            code_q <= code_in;
        end
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(code_q) && $stable(kind_q))); // R10

endmodule

// File: rtl/dlyseq_poll_ctr.sv
// Poll budget counter: counts failed lock reads, flags the final allowed
// read. Assumes clear and step are never high together.
module dlyseq_poll_ctr #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt;

    // Count reads that returned no lock in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_IDX);

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX); // R8
    AST_NO_STEP_PAST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !step); // R8

endmodule

// File: rtl/dlyseq_fsm.sv
// Sequencer core: walks the fixed read/modify/write chain over the
// register bus, polls lock, and reports the result. Assumes one
// outstanding transaction; bus_rdata and bus_err are valid with bus_ack.
module dlyseq_fsm
    import dlyseq_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 12'h1B0,
    parameter logic [ADDR_W-1:0] DLY_ADDR  = 12'h1B4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h1B8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    output logic              accept,
    input  dly_kind_e         kind_q,
    input  logic [DLY_W-1:0]  code_q,
    output logic              poll_clear,
    output logic              poll_step,
    input  logic              poll_last,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic [1:0]        done_cause,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output word_t             bus_wdata,
    input  word_t             bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    seq_state_e  state, nxt;
    seq_result_e cause, fin_cause;
    logic        fin;
    word_t       shadow;
    logic        is_read;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_FINISH);
    assign done_err  = done && (cause != RES_OK);
    assign done_cause = done ? cause : RES_OK;

    // Decode which states drive a transaction, and its direction.
    always_comb begin
        bus_req = 1'b0;
        bus_we  = 1'b0;
        is_read = 1'b0;
        case (state)
            S_RD_CTL_A, S_RD_DLY, S_RD_CTL_B, S_POLL: begin
                bus_req = 1'b1;
                is_read = 1'b1;
            end
            S_WR_CTL_A, S_WR_DLY, S_WR_CTL_B: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Pick the register address for the current step.
    always_comb begin
        case (state)
            S_RD_DLY, S_WR_DLY: bus_addr = DLY_ADDR;
            S_POLL:             bus_addr = STAT_ADDR;
            default:            bus_addr = CTL_ADDR;
        endcase
    end

    // Form write data from the last word read.
    always_comb begin
        case (state)
            S_WR_CTL_A: bus_wdata = ctl_prepare(shadow);
            S_WR_DLY:   bus_wdata = dly_merge(shadow, kind_q, code_q);
            S_WR_CTL_B: bus_wdata = ctl_commit(shadow);
            default:    bus_wdata = '0;
        endcase
    end

    // Next-state and poll-counter control.
    always_comb begin
        nxt        = state;
        fin        = 1'b0;
        fin_cause  = RES_OK;
        poll_clear = 1'b0;
        poll_step  = 1'b0;
        case (state)
            S_IDLE:   if (req_valid) nxt = S_RD_CTL_A;
            S_FINISH: nxt = S_IDLE;
            default: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        nxt       = S_FINISH;
                        fin       = 1'b1;
                        fin_cause = RES_BUS;
                    end else begin
                        case (state)
                            S_RD_CTL_A: nxt = S_WR_CTL_A;
                            S_WR_CTL_A: nxt = S_RD_DLY;
                            S_RD_DLY:   nxt = S_WR_DLY;
                            S_WR_DLY:   nxt = S_RD_CTL_B;
                            S_RD_CTL_B: nxt = S_WR_CTL_B;
                            S_WR_CTL_B: begin
                                nxt        = S_POLL;
                                poll_clear = 1'b1;
                            end
                            S_POLL: begin
                                if (bus_rdata[LOCKED_BIT]) begin
                                    nxt = S_FINISH;
                                    fin = 1'b1;
                                end else if (poll_last) begin
                                    nxt       = S_FINISH;
                                    fin       = 1'b1;
                                    fin_cause = RES_NOLOCK;
                                end else begin
                                    poll_step = 1'b1;
                                end
                            end
                            default: nxt = S_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    // State, read shadow and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            shadow <= '0;
            cause  <= RES_OK;
        end else begin
            state <= nxt;
            if (bus_ack && !bus_err && is_read) shadow <= bus_rdata;
            if (fin) cause <= fin_cause;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R3
    AST_ABORT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_err) |=> (!bus_req && done && done_err)); // R9
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !done) |=> busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R1

endmodule

// File: rtl/dll_delay_programmer.sv
// Top level of the DLL delay-line programming sequencer: joins request
// capture, poll budget and sequencing core. Assumes a single-master
// register bus with one outstanding transaction.
module dll_delay_programmer
    import dlyseq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                MAX_POLLS = 1000,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 12'h1B0,
    parameter logic [ADDR_W-1:0] DLY_ADDR  = 12'h1B4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h1B8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic [6:0]        req_code,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic [1:0]        done_cause,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    logic             accept;
    dly_kind_e        kind_q;
    logic [DLY_W-1:0] code_q;
    logic             poll_clear, poll_step, poll_last;

    dlyseq_req_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .busy    (busy),
        .kind_in (req_kind),
        .code_in (req_code),
        .kind_q  (kind_q),
        .code_q  (code_q)
    );

    dlyseq_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (poll_step),
        .last  (poll_last)
    );

    dlyseq_fsm #(
        .ADDR_W    (ADDR_W),
        .CTL_ADDR  (CTL_ADDR),
        .DLY_ADDR  (DLY_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .accept     (accept),
        .kind_q     (kind_q),
        .code_q     (code_q),
        .poll_clear (poll_clear),
        .poll_step  (poll_step),
        .poll_last  (poll_last),
        .busy       (busy),
        .done       (done),
        .done_err   (done_err),
        .done_cause (done_cause),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err)
    );

endmodule

// File: tb/sim_dll_delay_programmer.sv
// Scoreboard bench: the driver loads a register model, pushes the expected
// outcome and issues a request; the monitor pops and compares on done.
module sim_dll_delay_programmer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [6:0]  req_code = '0;
    logic        req_ready, busy, done, done_err;
    logic [1:0]  done_cause;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err;

    always #10 clk = ~clk;

    dll_delay_programmer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_code(req_code), .busy(busy), .done(done),
        .done_err(done_err), .done_cause(done_cause), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    typedef struct {
        string       name;
        logic [1:0]  cause;
        logic [31:0] r0;
        logic [31:0] r1;
        int          writes;
        int          polls;
    } exp_t;

    exp_t exp_q[$];

    // Driver-owned model controls.
    logic        load = 1'b0;
    logic [31:0] init0, init1;
    int          lock_lat = 0;
    int          err_at = -1;
    logic        chk_reset = 1'b0;

    // Model-owned state.
    logic [31:0] m_r0, m_r1;
    int          m_txn, m_writes, m_polls, m_bad_order;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    logic prev_done = 1'b0;
    logic rdy_bad = 1'b0;

    // Register model: ack one cycle after request, optional error inject.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
            bus_rdata <= '0;
            m_txn <= 0; m_writes <= 0; m_polls <= 0; m_bad_order <= 0;
            m_r0 <= '0; m_r1 <= '0;
        end else if (load) begin
            m_r0 <= init0; m_r1 <= init1;
            m_txn <= 0; m_writes <= 0; m_polls <= 0; m_bad_order <= 0;
            bus_ack <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            logic [11:0] ea;
            logic        ew;
            ea = (m_txn >= 6) ? 12'h1B8 : ((m_txn == 2 || m_txn == 3) ? 12'h1B4 : 12'h1B0);
            ew = (m_txn == 1 || m_txn == 3 || m_txn == 5);
            if (bus_addr != ea || bus_we != ew) m_bad_order <= m_bad_order + 1;
            bus_ack <= 1'b1;
            m_txn <= m_txn + 1;
            if (m_txn == err_at) begin
                bus_err <= 1'b1;
            end else begin
                bus_err <= 1'b0;
                if (bus_we) begin
                    m_writes <= m_writes + 1;
                    if (bus_addr == 12'h1B0) m_r0 <= bus_wdata;
                    if (bus_addr == 12'h1B4) m_r1 <= bus_wdata;
                end else if (bus_addr == 12'h1B0) bus_rdata <= m_r0;
                else if (bus_addr == 12'h1B4) bus_rdata <= m_r1;
                else begin
                    m_polls <= m_polls + 1;
                    bus_rdata <= 32'hC0DE_F01B |
                        ((lock_lat != 0 && m_polls + 1 >= lock_lat) ? 32'h4 : 32'h0);
                end
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: reset check, ready/busy watch, scoreboard compare, watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
        if (chk_reset)
            chk("R1 reset outputs", {busy, done, bus_req, req_ready} == 4'b0001,
                {28'd0, busy, done, bus_req, req_ready}, 32'h1);
        if (rst_n && busy && req_ready) rdy_bad = 1'b1;
        if (prev_done)
            chk("R2 idle after done", !busy && req_ready, {31'd0, busy}, 32'h0);
        prev_done = done;
        if (done) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected done", 1'b0, 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.name, " R7 R8 R9 cause"}, done_cause == e.cause && done_err == (e.cause != 0),
                    {29'd0, done_err, done_cause}, {29'd0, e.cause != 0, e.cause});
                chk({e.name, " R4 R6 ctl word"}, m_r0 == e.r0, m_r0, e.r0);
                chk({e.name, " R5 dly word"}, m_r1 == e.r1, m_r1, e.r1);
                chk({e.name, " R9 write count"}, m_writes == e.writes, m_writes, e.writes);
                chk({e.name, " R7 R8 poll count"}, m_polls == e.polls, m_polls, e.polls);
                chk({e.name, " R3 order"}, m_bad_order == 0, m_bad_order, 0);
                chk({e.name, " R10 ready low while busy"}, !rdy_bad, {31'd0, rdy_bad}, 0);
                rdy_bad = 1'b0;
            end
        end
    end

    // Compute expected outcome from the requirements and issue a request.
    task automatic run(input string name, input logic kind, input logic [6:0] code,
                       input int lat, input int eat, input logic poke);
        exp_t e;
        logic [31:0] a0, b0, d1;
        int eff;
        eff = (eat < 0) ? 1000000 : eat;
        a0 = (init0 & ~32'h01F7_01FF) | 32'h0004_0004;
        b0 = (a0 & ~32'h0007_01FF) | 32'h0004_0104;
        d1 = kind ? ((init1 & ~32'h0000_007F) | {25'd0, code})
                  : ((init1 & ~32'h0000_7F00) | {17'd0, code, 8'd0});
        e.name = name;
        e.r0 = (eff > 5) ? b0 : ((eff > 1) ? a0 : init0);
        e.r1 = (eff > 3) ? d1 : init1;
        e.writes = (eff > 1 ? 1 : 0) + (eff > 3 ? 1 : 0) + (eff > 5 ? 1 : 0);
        if (eat >= 0) begin
            e.cause = 2'd1;
            e.polls = (eat >= 6) ? eat - 6 : 0;
        end else if (lat >= 1 && lat <= 1000) begin
            e.cause = 2'd0;
            e.polls = lat;
        end else begin
            e.cause = 2'd2;
            e.polls = 1000;
        end
        @(negedge clk);
        lock_lat = lat; err_at = eat; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        exp_q.push_back(e);
        req_valid = 1'b1; req_kind = kind; req_code = code;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R10: offer a different request and change inputs while busy.
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_kind = ~kind; req_code = ~code;
            repeat (4) @(negedge clk);
            req_valid = 1'b0;
        end
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        init0 = 32'hABCD_EFFF; init1 = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_reset = 1'b1;
        @(negedge clk);
        chk_reset = 1'b0;
        run("sample lock3", 1'b0, 7'h55, 3, -1, 1'b0);
        init0 = 32'hFFFF_FFFF; init1 = 32'hFFFF_FFFF;
        run("R11 strobe preset 32", 1'b1, 7'd32, 1, -1, 1'b0);
        init0 = 32'h0000_0000; init1 = 32'h0000_0000;
        run("sample max code", 1'b0, 7'h7F, 2, -1, 1'b0);
        init0 = 32'h5A5A_A5A5; init1 = 32'hA5A5_5A5A;
        run("R10 busy poke", 1'b0, 7'h2B, 5, -1, 1'b1);
        run("R8 timeout", 1'b1, 7'h11, 0, -1, 1'b0);
        run("R7 lock on last read", 1'b1, 7'h22, 1000, -1, 1'b0);
        run("R9 err first write", 1'b0, 7'h33, 2, 1, 1'b0);
        run("R9 err second ctl read", 1'b1, 7'h44, 2, 4, 1'b0);
        run("R9 err during poll", 1'b0, 7'h66, 10, 8, 1'b0);
        run("after error recovery", 1'b1, 7'h01, 1, -1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule